// File: doc/BRIEF.md
# Debug Session State Controller

This controller follows a processor core through a debug session and moves it between its run state and a debug state. Any of several debug request lines opens a session. The controller then asks the core to halt. The core finishes its current instruction and signals completion. After that the controller reports the debug state and waits for Go commands. The run condition the core had when the session opened is latched as a 2-bit code and presented as the state to restore when the session closes.

The session and the debug state are tracked separately. A Go command without the exit flag releases the core for one instruction only, and the session stays open during that step. A Go command with the exit flag closes the session, unless a new request is already pending. In that case the core stays in the debug state. Each Go must be preceded by a fresh scan strobe. A Go that arrives without one is dropped and raises a sticky error bit.

Top module: `dbgsess_top`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it is released, sessionActive, inDebug, haltReq, stepEn, restoreValid and cmdErr are all 0. An accepted Go requires a scan strobe after reset.
- R2: In the idle condition, a high level on any one debug request line, sampled at a clock edge, makes sessionActive and haltReq 1 after that edge, with inDebug 0. The run-state code is latched at that same edge, using the encoding normal=00, stopped=01, halted=10, checkstop=11.
- R3: haltReq stays 1 until instrDone is sampled high. After that edge, inDebug is 1 and haltReq is 0.
- R4: clearWait is 1 combinationally while the controller is idle, waitMode is 1 and any request line is high.
- R5: In the debug state, an accepted Go with goExit=0 drives stepEn high for exactly one cycle after the edge and clears inDebug, while sessionActive stays 1. inDebug returns to 1 at the edge after instrDone is sampled high.
- R6: In the debug state, an accepted Go with goExit=1 and no request line high sets sessionActive and inDebug to 0 after that edge. restoreValid is 1 for exactly that one cycle, and restoreState holds the code latched at session start.
- R7: An accepted Go with goExit=1 while a request line is high keeps inDebug and sessionActive at 1, and restoreValid stays 0.
- R8: A Go in the debug state with no scan strobe since the previous accepted Go (or since reset) has no effect on inDebug or stepEn, and sets cmdErr. cmdErr stays set until a scan strobe clears it at the next edge. A scan in the same cycle as a Go arms the following Go.
- R9: restoreState does not change for the whole session, even when runState changes.
- R10: A Go strobe outside the debug state (idle, halting or stepping) is ignored: no state change and no cmdErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgReq | input | NUM_REQ | Debug request lines |
| runState | input | 2 | Current run condition of the core |
| waitMode | input | 1 | Core is in low-power wait |
| instrDone | input | 1 | Core finished its instruction |
| scanStrobe | input | 1 | Register image freshly scanned |
| goCmd | input | 1 | Decoded Go command |
| goExit | input | 1 | Exit flag of the Go command |
| sessionActive | output | 1 | Debug session in progress |
| inDebug | output | 1 | Core currently in the debug state |
| cmdErr | output | 1 | Sticky rejected-Go status |
| haltReq | output | 1 | Request to the core to halt into debug |
| stepEn | output | 1 | One-cycle single-step execute pulse |
| clearWait | output | 1 | Wake the core from low-power wait |
| restoreState | output | 2 | Run-state code to restore at exit |
| restoreValid | output | 1 | One-cycle pulse when the session closes |

## Verification
The assertions assume that instrDone comes from a core that answers a halt or a step. The check that debug entry follows a completion handshake relies on this. The bench therefore raises instrDone for one cycle only after it has seen haltReq or stepEn. It sweeps every request line against every run-state code, changes runState in the middle of each session, and keeps scan and Go strobes one cycle wide.

// File: rtl/dbgsess_pkg.sv
package dbgsess_pkg;

  localparam int RUN_W = 2;

  typedef enum logic [2:0] {
    SES_IDLE,
    SES_HALTING,
    SES_DEBUG,
    SES_STEP,
    SES_STEPWAIT
  } sesState_e;

  typedef enum logic [RUN_W-1:0] {
    RUN_NORMAL    = 2'b00,
    RUN_STOPPED   = 2'b01,
    RUN_HALTED    = 2'b10,
    RUN_CHECKSTOP = 2'b11
  } runCode_e;

  typedef struct packed {
    logic captureState;
    logic goAccept;
    logic goReject;
    logic exitDone;
  } ctrlStrobe_t;

endpackage

// File: rtl/dbgsess_ctrl.sv
module dbgsess_ctrl
  import dbgsess_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] dbgReq,
  input  logic               waitMode,
  input  logic               instrDone,
  input  logic               goCmd,
  input  logic               goExit,
  input  logic               scanArmed,
  output ctrlStrobe_t        strb,
  output logic               sessionActive,
  output logic               inDebug,
  output logic               haltReq,
  output logic               stepEn,
  output logic               clearWait
);

  sesState_e state, stateNext;
  logic reqPending;
  logic goSeen;

  assign reqPending = |dbgReq;
  assign goSeen     = goCmd && (state == SES_DEBUG);

  always_comb begin
    stateNext         = state;
    strb              = '0;
    strb.goAccept     = goSeen && scanArmed;
    strb.goReject     = goSeen && !scanArmed;
    unique case (state)
      SES_IDLE: begin
        if (reqPending) begin
          stateNext         = SES_HALTING;
          strb.captureState = 1'b1;
        end
      end
      SES_HALTING: begin
        if (instrDone) stateNext = SES_DEBUG;
      end
      SES_DEBUG: begin
        if (strb.goAccept) begin
          if (!goExit) begin
            stateNext = SES_STEP;
          end else if (reqPending) begin
            stateNext = SES_DEBUG;
          end else begin
            stateNext     = SES_IDLE;
            strb.exitDone = 1'b1;
          end
        end
      end
      SES_STEP: begin
        stateNext = SES_STEPWAIT;
      end
      SES_STEPWAIT: begin
        if (instrDone) stateNext = SES_DEBUG;
      end
      default: stateNext = SES_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SES_IDLE;
    else       state <= stateNext;
  end

  assign sessionActive = (state != SES_IDLE);
  assign inDebug       = (state == SES_DEBUG);
  assign haltReq       = (state == SES_HALTING);
  assign stepEn        = (state == SES_STEP);
  assign clearWait     = (state == SES_IDLE) && waitMode && reqPending;

  AST_STEP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stepEn |=> !stepEn); // R5
  AST_ENTRY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inDebug) |-> $past(instrDone)); // R3
  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.goAccept && goExit && !reqPending) |=> !sessionActive); // R6
  AST_PENDING_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.goAccept && goExit && reqPending) |=> (inDebug && sessionActive)); // R7

endmodule

// File: rtl/dbgsess_dpath.sv
module dbgsess_dpath
  import dbgsess_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [RUN_W-1:0] runState,
  input  logic             scanStrobe,
  input  logic             sessionActive,
  output logic             scanArmed,
  output logic             cmdErr,
  output logic [RUN_W-1:0] savedState,
  output logic             restoreValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedState   <= RUN_NORMAL;
      scanArmed    <= 1'b0;
      cmdErr       <= 1'b0;
      restoreValid <= 1'b0;
    end else begin
      if (strb.captureState) savedState <= runState;
      if (scanStrobe)         scanArmed <= 1'b1;
      else if (strb.goAccept) scanArmed <= 1'b0;
      if (scanStrobe)         cmdErr <= 1'b0;
      else if (strb.goReject) cmdErr <= 1'b1;
      restoreValid <= strb.exitDone;
    end
  end

  AST_GO_NEEDS_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    strb.goAccept |-> scanArmed); // R8
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    scanStrobe |=> !cmdErr); // R8
  AST_SAVED_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (sessionActive && $past(sessionActive)) |-> $stable(savedState)); // R9
  AST_RESTORE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |=> !restoreValid); // R6

endmodule

// File: rtl/dbgsess_top.sv
module dbgsess_top
  import dbgsess_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] dbgReq,
  input  logic [1:0]         runState,
  input  logic               waitMode,
  input  logic               instrDone,
  input  logic               scanStrobe,
  input  logic               goCmd,
  input  logic               goExit,
  output logic               sessionActive,
  output logic               inDebug,
  output logic               cmdErr,
  output logic               haltReq,
  output logic               stepEn,
  output logic               clearWait,
  output logic [1:0]         restoreState,
  output logic               restoreValid
);

  ctrlStrobe_t strb;
  logic        scanArmed;

  dbgsess_ctrl #(.NUM_REQ(NUM_REQ)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .dbgReq       (dbgReq),
    .waitMode     (waitMode),
    .instrDone    (instrDone),
    .goCmd        (goCmd),
    .goExit       (goExit),
    .scanArmed    (scanArmed),
    .strb         (strb),
    .sessionActive(sessionActive),
    .inDebug      (inDebug),
    .haltReq      (haltReq),
    .stepEn       (stepEn),
    .clearWait    (clearWait)
  );

  dbgsess_dpath dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .runState     (runState),
    .scanStrobe   (scanStrobe),
    .sessionActive(sessionActive),
    .scanArmed    (scanArmed),
    .cmdErr       (cmdErr),
    .savedState   (restoreState),
    .restoreValid (restoreValid)
  );

endmodule

// File: tb/dbgsess_top_tb.sv
`timescale 1ns/1ps
module dbgsess_top_tb_top;

  localparam int NREQ = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NREQ-1:0] dbgReq = '0;
  logic [1:0]      runState = 2'b00;
  logic            waitMode = 1'b0;
  logic            instrDone = 1'b0;
  logic            scanStrobe = 1'b0;
  logic            goCmd = 1'b0;
  logic            goExit = 1'b0;
  logic            sessionActive, inDebug, cmdErr, haltReq, stepEn, clearWait, restoreValid;
  logic [1:0]      restoreState;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbgsess_top #(.NUM_REQ(NREQ)) dut_i (
    .clk(clk), .rstN(rstN), .dbgReq(dbgReq), .runState(runState),
    .waitMode(waitMode), .instrDone(instrDone), .scanStrobe(scanStrobe),
    .goCmd(goCmd), .goExit(goExit), .sessionActive(sessionActive),
    .inDebug(inDebug), .cmdErr(cmdErr), .haltReq(haltReq), .stepEn(stepEn),
    .clearWait(clearWait), .restoreState(restoreState), .restoreValid(restoreValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulseScan();
    scanStrobe = 1'b1; tick(); scanStrobe = 1'b0;
  endtask

  task automatic pulseGo(input logic ex);
    goCmd = 1'b1; goExit = ex; tick(); goCmd = 1'b0; goExit = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 session in reset", sessionActive, 0);
    chk("R1 haltReq in reset", haltReq, 0);
    tick(); tick();
    rstN = 1'b1;
    tick();
    chk("R1 inDebug", inDebug, 0);
    chk("R1 stepEn", stepEn, 0);
    chk("R1 restoreValid", restoreValid, 0);
    chk("R1 cmdErr", cmdErr, 0);

    // R10: Go while idle is ignored
    pulseGo(1'b0);
    chk("R10 idle go session", sessionActive, 0);
    chk("R10 idle go err", cmdErr, 0);

    for (int ln = 0; ln < NREQ; ln++) begin
      for (int rs = 0; rs < 4; rs++) begin
        runState = rs[1:0];
        waitMode = 1'b1;
        dbgReq = '0; dbgReq[ln] = 1'b1;
        #1;
        chk("R4 clearWait", clearWait, 1);
        tick();
        chk("R2 session", sessionActive, 1);
        chk("R2 haltReq", haltReq, 1);
        chk("R2 inDebug", inDebug, 0);
        chk("R4 clearWait off when halting", clearWait, 0);
        dbgReq = '0; waitMode = 1'b0;
        runState = ~rs[1:0];
        if (ln == 0 && rs == 0) begin
          pulseGo(1'b0);
          chk("R10 halting go err", cmdErr, 0);
          chk("R10 halting go state", haltReq, 1);
        end
        tick();
        chk("R3 haltReq held", haltReq, 1);
        instrDone = 1'b1; tick(); instrDone = 1'b0;
        chk("R3 inDebug", inDebug, 1);
        chk("R3 haltReq drop", haltReq, 0);
        chk("R9 restoreState", restoreState, rs);

        // single step
        pulseScan();
        pulseGo(1'b0);
        chk("R5 stepEn", stepEn, 1);
        chk("R5 inDebug low", inDebug, 0);
        chk("R5 session kept", sessionActive, 1);
        if (ln == 1 && rs == 1) begin
          pulseGo(1'b1);
          chk("R10 step go err", cmdErr, 0);
        end else begin
          tick();
        end
        chk("R5 stepEn one cycle", stepEn, 0);
        chk("R5 wait for done", inDebug, 0);
        instrDone = 1'b1; tick(); instrDone = 1'b0;
        chk("R5 back in debug", inDebug, 1);

        // go with no fresh scan
        if (rs == 2) begin
          pulseGo(1'b0);
          chk("R8 err set", cmdErr, 1);
          chk("R8 no step", stepEn, 0);
          chk("R8 still debug", inDebug, 1);
          tick();
          chk("R8 err sticky", cmdErr, 1);
          pulseScan();
          chk("R8 err cleared", cmdErr, 0);
        end

        // exit with request pending
        if (ln % 2 == 1) begin
          dbgReq[ln] = 1'b1;
          pulseScan();
          pulseGo(1'b1);
          chk("R7 stay debug", inDebug, 1);
          chk("R7 session", sessionActive, 1);
          chk("R7 no restore", restoreValid, 0);
          dbgReq = '0;
        end

        pulseScan();
        pulseGo(1'b1);
        chk("R6 session end", sessionActive, 0);
        chk("R6 inDebug", inDebug, 0);
        chk("R6 restoreValid", restoreValid, 1);
        chk("R6 restoreState", restoreState, rs);
        tick();
        chk("R6 restore pulse", restoreValid, 0);
      end
    end

    // R8: scan in the same cycle as a rejected Go arms the next Go
    dbgReq = 1; tick(); dbgReq = '0;
    instrDone = 1'b1; tick(); instrDone = 1'b0;
    scanStrobe = 1'b1; goCmd = 1'b1; tick(); scanStrobe = 1'b0; goCmd = 1'b0;
    chk("R8 same-cycle scan err", cmdErr, 0);
    pulseGo(1'b1);
    chk("R8 armed go exits", sessionActive, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule